// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR-flash bus and turns one request into a full embedded-operation command sequence. A request carries an operation code, a word address and a data word. The block issues the unlock and command write cycles: four for a word program, six for a sector or chip erase. It then reads status from the target address until the device reports that the operation has finished, and signals completion with a one-cycle `done_o` pulse. A timeout flag accompanies that pulse when completion was never seen.

Every strobe phase is timed by counting system clocks. Each minimum is a nanosecond parameter that is rounded up to whole clocks at the configured clock period. Each bus cycle begins with an address-valid pulse. A write cycle then holds a write-enable low pulse followed by a write-enable high recovery. A read cycle holds an output-enable low window, samples the data at the end of that window, and then leaves a gap. Completion is decided by comparing the toggle-bit positions of two consecutive status reads. Polling is bounded by a clock count for program and by a microsecond count for erase, which is kept by a prescaled counter.

Top module: `flash_seq`

## Requirements
- R1: During and after reset, with no request, `fl_ce_no`, `fl_we_no`, `fl_oe_no` and `fl_avd_no` are high, `fl_dq_oe_o` is low, and `busy_o` and `done_o` are low.
- R2: Operation code 0 (program) issues exactly four write cycles in this order: 0xAA at 0x555, 0x55 at 0x2AA, 0xA0 at 0x555, then the request data at the request address. Unlock addresses have all upper address bits zero.
- R3: Operation code 1 (sector erase) issues six write cycles in this order: 0xAA/0x555, 0x55/0x2AA, 0x80/0x555, 0xAA/0x555, 0x55/0x2AA, then 0x30 at the request address.
- R4: Operation code 2 (chip erase) issues the same first five write cycles as R3. The sixth write cycle is 0x10 at 0x555.
- R5: Write-enable stays low for exactly max(ceil(WP_NS), ceil(DS_NS)) clocks. Between write cycles of one operation it stays high for exactly ceil(WPH_NS) + ceil(AVD_NS) clocks.
- R6: Every bus cycle, write or read, is preceded by exactly one address-valid low pulse of ceil(AVD_NS) clocks. Address-valid is high whenever write-enable or output-enable falls.
- R7: Chip-enable is low for the whole time `busy_o` is high, and it returns high once the operation completes.
- R8: Write-enable and output-enable are never low together. `fl_dq_oe_o` is high at every write-enable rising edge and low whenever output-enable is low.
- R9: Each status read holds output-enable low for ceil(OE_NS) clocks at the request address and samples data at the end of that window. Polling stops at the first read whose bits under TOGGLE_MASK (default bits 6 and 2) equal those of the previous read. `done_o` then pulses for one cycle with `timeout_o` low. Bits outside the mask are ignored.
- R10: For a program, if completion has not been seen once PROG_TMO_US microseconds of clocks have elapsed since polling started, the next status read ends the operation with `done_o` and `timeout_o` both high.
- R11: For an erase, the same timeout rule applies, with the elapsed time counted in whole microsecond ticks against ERASE_TMO_US.
- R12: A request is accepted only while the block is idle. A request presented while `busy_o` is high has no effect on the bus sequence of the operation in progress, and it starts no later operation.
- R13: Operation code 3 is ignored. No bus cycle is issued and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 ignored |
| req_addr_i | input | AW | Program or sector address, also the status read address |
| req_data_i | input | DW | Program data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Valid with done_o: polling limit reached |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |
| fl_avd_no | output | 1 | Flash address-valid strobe, active low |
| fl_addr_o | output | AW | Flash address bus |
| fl_dq_o | output | DW | Flash data bus, outgoing value |
| fl_dq_oe_o | output | 1 | Data bus drive enable; low releases the bus |
| fl_dq_i | input | DW | Flash data bus, incoming value |

## Verification
The bench keeps the default 10 ns clock and default strobe times, which give 1, 5, 3, 4 and 2 clocks for the address-valid, write-low, write-high, read-low and read-gap phases. Every exact pulse width can therefore be measured in whole clocks. The program limit is reduced to 2 us (200 clocks) and the erase limit to 3 us (three prescaled ticks of 100 clocks). With these values, both timeout paths and the prescaler roll-over are reached within a few hundred cycles, using a flash model that toggles status forever. The same model settles after a chosen number of reads, which fixes the expected read count of the normal completion path.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_CHIP = 2'd2,
    OP_NONE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_W_AVD,
    S_W_WEL,
    S_W_WEH,
    S_R_AVD,
    S_R_OEL,
    S_R_OEH,
    S_FIN
  } state_e;

  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/flash_seq_cmd.sv
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  op_e           op_i,
  input  logic [2:0]    idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] cyc_addr_o,
  output logic [DW-1:0] cyc_data_o,
  output logic          last_o
);

  localparam logic [AW-1:0] A_HI = AW'('h555);
  localparam logic [AW-1:0] A_LO = AW'('h2AA);

  always_comb begin
    last_o = (op_i == OP_PROG) ? (idx_i == 3'd3) : (idx_i == 3'd5);
    unique case (idx_i)
      3'd0: begin cyc_addr_o = A_HI; cyc_data_o = DW'('hAA); end
      3'd1: begin cyc_addr_o = A_LO; cyc_data_o = DW'('h55); end
      3'd2: begin
        cyc_addr_o = A_HI;
        cyc_data_o = (op_i == OP_PROG) ? DW'('hA0) : DW'('h80);
      end
      3'd3: begin
        cyc_addr_o = (op_i == OP_PROG) ? addr_i : A_HI;
        cyc_data_o = (op_i == OP_PROG) ? data_i : DW'('hAA);
      end
      3'd4: begin cyc_addr_o = A_LO; cyc_data_o = DW'('h55); end
      default: begin
        cyc_addr_o = (op_i == OP_CHIP) ? A_HI : addr_i;
        cyc_data_o = (op_i == OP_CHIP) ? DW'('h10) : DW'('h30);
      end
    endcase
  end

endmodule

// File: rtl/flash_seq_phase_cnt.sv
module flash_seq_phase_cnt #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/flash_seq_tmo.sv
module flash_seq_tmo #(
  parameter int PROG_LIM  = 50000,
  parameter int TICK_CLK  = 100,
  parameter int ERASE_LIM = 200000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic erase_i,
  output logic expired_o
);

  localparam int LMAX = (PROG_LIM > ERASE_LIM) ? PROG_LIM : ERASE_LIM;
  localparam int EW   = $clog2(LMAX + 1);

  logic          tick;
  logic [EW-1:0] elapsed_q;
  logic [EW-1:0] lim;

  generate
    if (TICK_CLK > 1) begin : g_pre
      localparam int PW = $clog2(TICK_CLK);
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_CLK - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       pre_q <= '0;
        else if (clear_i)  pre_q <= '0;
        else if (erase_i)  pre_q <= tick ? '0 : pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign lim = erase_i ? EW'(ERASE_LIM) : EW'(PROG_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   elapsed_q <= '0;
    else if (clear_i)                              elapsed_q <= '0;
    else if ((erase_i ? tick : 1'b1) && elapsed_q < lim) elapsed_q <= elapsed_q + 1'b1;
  end

  assign expired_o = (elapsed_q >= lim);

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int AW            = 21,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int AVD_NS        = 10,
  parameter int WP_NS         = 50,
  parameter int DS_NS         = 45,
  parameter int WPH_NS        = 30,
  parameter int OE_NS         = 40,
  parameter int OEH_NS        = 20,
  parameter int PROG_TMO_US   = 500,
  parameter int ERASE_TMO_US  = 200000000,
  parameter logic [DW-1:0] TOGGLE_MASK = DW'('h44)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_op_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          timeout_o,
  output logic          fl_ce_no,
  output logic          fl_we_no,
  output logic          fl_oe_no,
  output logic          fl_avd_no,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe_o,
  input  logic [DW-1:0] fl_dq_i
);

  localparam int AVD_CYC = ns2cyc(AVD_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = imax(ns2cyc(WP_NS, CLK_PERIOD_NS), ns2cyc(DS_NS, CLK_PERIOD_NS));
  localparam int WPH_CYC = ns2cyc(WPH_NS, CLK_PERIOD_NS);
  localparam int OE_CYC  = ns2cyc(OE_NS, CLK_PERIOD_NS);
  localparam int OEH_CYC = ns2cyc(OEH_NS, CLK_PERIOD_NS);
  localparam int MAXC    = imax(imax(AVD_CYC, WP_CYC), imax(WPH_CYC, imax(OE_CYC, OEH_CYC)));
  localparam int CW      = $clog2(MAXC) + 1;
  localparam int TICK    = ns2cyc(1000, CLK_PERIOD_NS);
  localparam int PLIM    = ns2cyc(PROG_TMO_US * 1000, CLK_PERIOD_NS);

  state_e        state_q, state_d;
  op_e           op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, samp_q;
  logic [2:0]    idx_q;
  logic          have_q, tmo_q;
  logic          load, zero, last, expired, settled, sample, poll_clear, req_ok, reading;
  logic [CW-1:0] load_val;
  logic [AW-1:0] cyc_addr;
  logic [DW-1:0] cyc_data;
  logic          ce_q, we_q, oe_q, avd_q, dqoe_q;

  flash_seq_phase_cnt #(.W(CW)) u_cnt (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .zero_o(zero)
  );

  flash_seq_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .op_i(op_q), .idx_i(idx_q), .addr_i(addr_q), .data_i(data_q),
    .cyc_addr_o(cyc_addr), .cyc_data_o(cyc_data), .last_o(last)
  );

  flash_seq_tmo #(.PROG_LIM(PLIM), .TICK_CLK(TICK), .ERASE_LIM(ERASE_TMO_US)) u_tmo (
    .clk_i, .rst_ni, .clear_i(poll_clear), .erase_i(op_q != OP_PROG), .expired_o(expired)
  );

  assign req_ok     = req_valid_i && (op_e'(req_op_i) != OP_NONE);
  assign settled    = have_q && (((fl_dq_i ^ samp_q) & TOGGLE_MASK) == '0);
  assign sample     = (state_q == S_R_OEL) && zero;
  assign poll_clear = (state_q == S_W_WEH) && zero && last;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      S_IDLE:  if (req_ok) begin state_d = S_W_AVD; load = 1'b1; load_val = CW'(AVD_CYC - 1); end
      S_W_AVD: if (zero)   begin state_d = S_W_WEL; load = 1'b1; load_val = CW'(WP_CYC - 1); end
      S_W_WEL: if (zero)   begin state_d = S_W_WEH; load = 1'b1; load_val = CW'(WPH_CYC - 1); end
      S_W_WEH: if (zero) begin
        state_d  = last ? S_R_AVD : S_W_AVD;
        load     = 1'b1;
        load_val = CW'(AVD_CYC - 1);
      end
      S_R_AVD: if (zero)   begin state_d = S_R_OEL; load = 1'b1; load_val = CW'(OE_CYC - 1); end
      S_R_OEL: if (zero) begin
        if (settled || expired) state_d = S_FIN;
        else begin state_d = S_R_OEH; load = 1'b1; load_val = CW'(OEH_CYC - 1); end
      end
      S_R_OEH: if (zero)   begin state_d = S_R_AVD; load = 1'b1; load_val = CW'(AVD_CYC - 1); end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROG;
      addr_q  <= '0;
      data_q  <= '0;
      idx_q   <= '0;
      samp_q  <= '0;
      have_q  <= 1'b0;
      tmo_q   <= 1'b0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      avd_q   <= 1'b1;
      dqoe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && req_ok) begin
        op_q   <= op_e'(req_op_i);
        addr_q <= req_addr_i;
        data_q <= req_data_i;
        idx_q  <= '0;
        tmo_q  <= 1'b0;
      end
      if (state_q == S_W_WEH && zero && !last) idx_q <= idx_q + 3'd1;
      if (poll_clear) have_q <= 1'b0;
      if (sample) begin
        samp_q <= fl_dq_i;
        have_q <= 1'b1;
        if (!settled && expired) tmo_q <= 1'b1;
      end
      // strobes registered from next state: glitch-free at the pins
      ce_q   <= (state_d == S_IDLE) || (state_d == S_FIN);
      we_q   <= (state_d != S_W_WEL);
      oe_q   <= (state_d != S_R_OEL);
      avd_q  <= !((state_d == S_W_AVD) || (state_d == S_R_AVD));
      dqoe_q <= (state_d == S_W_AVD) || (state_d == S_W_WEL) || (state_d == S_W_WEH);
    end
  end

  assign reading    = (state_q == S_R_AVD) || (state_q == S_R_OEL) || (state_q == S_R_OEH);
  assign fl_addr_o  = reading ? addr_q : cyc_addr;
  assign fl_dq_o    = cyc_data;
  assign fl_dq_oe_o = dqoe_q;
  assign fl_ce_no   = ce_q;
  assign fl_we_no   = we_q;
  assign fl_oe_no   = oe_q;
  assign fl_avd_no  = avd_q;
  assign busy_o     = (state_q != S_IDLE) && (state_q != S_FIN);
  assign done_o     = (state_q == S_FIN);
  assign timeout_o  = (state_q == S_FIN) && tmo_q;

  assert_we_oe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no));
  assert_dq_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_dq_oe_o);
  assert_ce_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !fl_ce_no);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_avd_before_we_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(fl_we_no) || $fell(fl_oe_no)) |-> fl_avd_no);
  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q)));

endmodule

// File: tb/flash_seq_tb.sv
module flash_seq_tb;

  localparam int CLK_NS = 10;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int E_AVD = 1, E_WP = 5, E_WPH = 3, E_OE = 4;

  logic          clk = 0, rst_ni = 0;
  logic          req_valid = 0;
  logic [1:0]    req_op = 0;
  logic [AW-1:0] req_addr = 0;
  logic [DW-1:0] req_data = 0;
  logic          busy, done, tmo;
  logic          ce_n, we_n, oe_n, avd_n, dq_oe;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_o, dq_i;

  int checks = 0, fails = 0;
  int cyc = 0, n_wr = 0, n_rd = 0, n_avd = 0, rd_cnt = 0, toggle_n = 0;
  int bad_we = 0, bad_gap = 0, bad_avd = 0, bad_oe = 0, bad_excl = 0, bad_rel = 0;
  int bad_rdaddr = 0, bad_ce = 0, bad_wrdrv = 0, last_rise = 0;
  int we_lo = 0, we_hi = 0, avd_lo = 0, oe_lo = 0;
  logic p_we = 1, p_avd = 1, p_oe = 1;
  logic [AW-1:0] exp_rd_addr = 0;
  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];

  always #(CLK_NS/2) clk = ~clk;

  flash_seq #(.AW(AW), .DW(DW), .CLK_PERIOD_NS(CLK_NS), .PROG_TMO_US(2), .ERASE_TMO_US(3)) u_dut (
    .clk_i(clk), .rst_ni, .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr),
    .req_data_i(req_data), .busy_o(busy), .done_o(done), .timeout_o(tmo),
    .fl_ce_no(ce_n), .fl_we_no(we_n), .fl_oe_no(oe_n), .fl_avd_no(avd_n),
    .fl_addr_o(addr), .fl_dq_o(dq_o), .fl_dq_oe_o(dq_oe), .fl_dq_i(dq_i)
  );

  // flash model: bit 6 toggles per read until toggle_n reads, upper byte always changes
  assign dq_i = {8'(rd_cnt), 1'b0, (rd_cnt >= toggle_n) ? 1'(toggle_n) : 1'(rd_cnt), 6'b0};

  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (!we_n) begin
        if (p_we) begin
          if (n_wr > 0 && we_hi != E_WPH + E_AVD) bad_gap++;
          we_lo = 1;
        end else we_lo++;
      end else begin
        if (!p_we) begin
          if (we_lo != E_WP) bad_we++;
          if (!dq_oe) bad_wrdrv++;
          if (n_wr < 8) begin wa[n_wr] = addr; wd[n_wr] = dq_o; end
          n_wr++;
          last_rise = cyc;
          we_hi = 1;
        end else we_hi++;
      end
      if (!avd_n) begin
        if (p_avd) begin n_avd++; avd_lo = 1; end else avd_lo++;
      end else if (!p_avd && avd_lo != E_AVD) bad_avd++;
      if (!oe_n) begin
        if (p_oe) begin n_rd++; oe_lo = 1; if (addr != exp_rd_addr) bad_rdaddr++; end
        else oe_lo++;
        if (dq_oe) bad_rel++;
      end else if (!p_oe) begin
        if (oe_lo != E_OE) bad_oe++;
        rd_cnt++;
      end
      if (!we_n && !oe_n) bad_excl++;
      if (busy && ce_n) bad_ce++;
      p_we = we_n; p_avd = avd_n; p_oe = oe_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    n_wr = 0; n_rd = 0; n_avd = 0; rd_cnt = 0;
    bad_we = 0; bad_gap = 0; bad_avd = 0; bad_oe = 0; bad_excl = 0; bad_rel = 0;
    bad_rdaddr = 0; bad_ce = 0; bad_wrdrv = 0;
  endtask

  task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int n, input bit inject, output bit t_o, output int dcyc);
    int k;
    clear_mon();
    toggle_n = n;
    exp_rd_addr = a;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    if (inject) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_op = 2'd1; req_addr = 21'h1F0000; req_data = 16'h1234;
      @(negedge clk);
      req_valid = 0;
    end
    t_o = 0; dcyc = 0;
    for (k = 0; k < 6000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1'b1, "R9 completion seen", int'(done), 1);
    t_o = tmo;
    dcyc = cyc - last_rise;
    @(negedge clk);
    chk(ce_n && !busy, "R7 idle after done", int'({ce_n, busy}), 2);
  endtask

  task automatic chk_bus(input int nw);
    chk(n_wr == nw, "R2 write count", n_wr, nw);
    chk(bad_we == 0 && bad_gap == 0, "R5 write pulse timing", bad_we + bad_gap, 0);
    chk(bad_avd == 0 && n_avd == n_wr + n_rd, "R6 address-valid pulses", n_avd, n_wr + n_rd);
    chk(bad_ce == 0, "R7 chip enable during op", bad_ce, 0);
    chk(bad_excl == 0 && bad_rel == 0 && bad_wrdrv == 0, "R8 bus drive", bad_excl + bad_rel + bad_wrdrv, 0);
    chk(bad_oe == 0 && bad_rdaddr == 0, "R9 read window and address", bad_oe + bad_rdaddr, 0);
  endtask

  task automatic chk_unlock(input int i, input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string r);
    chk(wa[i] == ea && wd[i] == ed, r, int'({wa[i], wd[i]}), int'({ea, ed}));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && avd_n && !dq_oe && !busy && !done, "R1 reset state",
        int'({ce_n, we_n, oe_n, avd_n, dq_oe, busy, done}), 7'b1111000);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(ce_n && we_n && oe_n && avd_n && !busy, "R1 idle after reset", int'({ce_n, busy}), 2);
  endtask

  task automatic t_program();
    bit t; int dc;
    run_op(2'd0, 21'h12345, 16'hBEEF, 3, 0, t, dc);
    chk_bus(4);
    chk_unlock(0, 21'h555, 16'hAA, "R2 cycle 1");
    chk_unlock(1, 21'h2AA, 16'h55, "R2 cycle 2");
    chk_unlock(2, 21'h555, 16'hA0, "R2 cycle 3");
    chk_unlock(3, 21'h12345, 16'hBEEF, "R2 cycle 4");
    chk(n_rd == 5 && !t, "R9 reads until settled", n_rd, 5);
  endtask

  task automatic t_sector();
    bit t; int dc;
    run_op(2'd1, 21'h0A8000, 16'h0, 5, 0, t, dc);
    chk_bus(6);
    chk_unlock(2, 21'h555, 16'h80, "R3 cycle 3");
    chk_unlock(3, 21'h555, 16'hAA, "R3 cycle 4");
    chk_unlock(4, 21'h2AA, 16'h55, "R3 cycle 5");
    chk_unlock(5, 21'h0A8000, 16'h30, "R3 final cycle");
    chk(n_rd == 7 && !t, "R9 erase reads until settled", n_rd, 7);
  endtask

  task automatic t_chip();
    bit t; int dc;
    run_op(2'd2, 21'h000100, 16'h0, 0, 0, t, dc);
    chk_bus(6);
    chk_unlock(0, 21'h555, 16'hAA, "R4 cycle 1");
    chk_unlock(5, 21'h555, 16'h10, "R4 final cycle");
    chk(n_rd == 2 && !t, "R9 two reads when stable", n_rd, 2);
  endtask

  task automatic t_prog_timeout();
    bit t; int dc;
    run_op(2'd0, 21'h00400, 16'h5A5A, 100000, 0, t, dc);
    chk(t == 1'b1, "R10 program timeout flag", int'(t), 1);
    chk(dc >= 200 && dc <= 235, "R10 program timeout delay", dc, 200);
  endtask

  task automatic t_erase_timeout();
    bit t; int dc;
    run_op(2'd1, 21'h010000, 16'h0, 100000, 0, t, dc);
    chk(t == 1'b1, "R11 erase timeout flag", int'(t), 1);
    chk(dc >= 300 && dc <= 335, "R11 erase timeout delay", dc, 300);
  endtask

  task automatic t_busy_ignore();
    bit t; int dc;
    run_op(2'd0, 21'h00777, 16'hC3C3, 1, 1, t, dc);
    chk(n_wr == 4, "R12 write count unchanged", n_wr, 4);
    chk_unlock(3, 21'h00777, 16'hC3C3, "R12 program cycle intact");
    repeat (10) @(negedge clk);
    chk(!busy && n_wr == 4, "R12 no later operation", n_wr, 4);
  endtask

  task automatic t_bad_op();
    clear_mon();
    @(negedge clk);
    req_valid = 1; req_op = 2'd3; req_addr = 21'h5; req_data = 16'h1;
    @(negedge clk);
    req_valid = 0;
    repeat (20) @(negedge clk);
    chk(!busy && n_avd == 0 && ce_n, "R13 code 3 ignored", n_avd, 0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_program();
    t_sector();
    t_chip();
    t_prog_timeout();
    t_erase_timeout();
    t_busy_ignore();
    t_bad_op();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule